// File: doc/BRIEF.md
# Sequencing Converter Readout Host Controller

This block sits on the host side of a parallel bus that connects to a four-input converter with a built-in sequencer. It accepts a measurement request that carries a channel mask. It writes that mask into the converter's select register with a chip-select/write pulse and then raises the start strobe. After that it follows the converter's end-of-conversion pulses. It makes exactly one read for each pulse, while the pulse is still low. Each 12-bit result comes out on a valid/data stream, tagged with its channel number and flagged when it is the final result of the sequence.

The converter returns results in ascending channel order, so the controller needs no channel information from the converter. It gives each read the tag of the lowest channel in the latched mask that has not been read yet. After the last read it stays busy for a programmable quiet interval, so that the data bus settles before the next start strobe. Pulse widths and the quiet interval are parameters counted in clock cycles. The end-of-conversion input is taken as synchronous to the controller clock.

Top module: `adc_seq_host`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip select, write and read are high (inactive), the start strobe is low, the bus driver is off, `res_valid` is low and `req_ready` is high.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high and `req_mask` is non-zero. A request with an all-zero mask causes no bus activity and leaves `req_ready` high. A request raised while `req_ready` is low is ignored and has no effect on the results.
- R3: The mask write holds chip select and write low, with read high, for `WR_CYC` cycles. It is followed by one cycle in which write and chip select are high. The host drives the data bus during both phases, with bit i of the driven value set when channel i is selected, so the mask is valid at the rising edge of write.
- R4: The start strobe rises only after the mask write has finished, and it stays high for exactly `START_CYC` cycles.
- R5: Each read holds chip select and read low for `RD_CYC` cycles and begins one cycle after end-of-conversion is seen low. Exactly one read is made per low pulse of end-of-conversion, however long the pulse lasts.
- R6: The data bus is sampled in the last cycle in which read is low. The sampled value appears on `res_data` with `res_valid` high for one cycle, in the cycle after that.
- R7: The channel tags of a sequence are the set bits of the accepted mask in ascending order, encoded as the bit index (0 to 3).
- R8: A sequence produces one result per set mask bit. `res_last` is high on the final result only.
- R9: After the last read of a sequence, `req_ready` stays low and no start strobe rises until read has been high for at least `QUIET_CYC` cycles.
- R10: The mask is latched when the request is accepted. Later changes on `req_mask` do not alter the tags or the number of results in the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Measurement request |
| req_mask | input | 4 | Channel selection, bit i = channel i |
| req_ready | output | 1 | High when idle and the quiet interval has elapsed |
| cv_cs_n | output | 1 | Converter chip select, active low |
| cv_wr_n | output | 1 | Converter write strobe, active low |
| cv_rd_n | output | 1 | Converter read strobe, active low |
| cv_start | output | 1 | Conversion start strobe, active on its rising edge |
| cv_eoc_n | input | 1 | End of conversion, low pulse per finished channel |
| cv_db_oe | output | 1 | Host drives the mask onto data bits 3:0 |
| cv_db_o | output | 4 | Mask value driven during the write |
| cv_db_i | input | 12 | Conversion result from the data bus |
| res_valid | output | 1 | Result valid, one-cycle pulse |
| res_data | output | 12 | Conversion result |
| res_chan | output | 2 | Channel tag |
| res_last | output | 1 | Final result of the sequence |

## Verification
The bench builds the block with `WR_CYC=2`, `START_CYC=2`, `RD_CYC=3` and `QUIET_CYC=5`. Multi-cycle write, start and read phases therefore occur, and the quiet window is longer than the gap between one read and the following end-of-conversion. The converter model draws conversion delays and end-of-conversion pulse lengths at random. Some pulses are much longer than a read, which tests the one-read-per-pulse rule. The quiet window then decides when the next request can be taken. Directed masks with a single low channel, a single high channel, all channels and sparse patterns test the ascending tag order and the last-result flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_WGAP  = 3'd2,
      ST_START = 3'd3,
      ST_WAIT  = 3'd4,
      ST_READ  = 3'd5,
      ST_EOCHI = 3'd6
   } seq_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
   parameter int NCH = 4,
   localparam int CW = $clog2(NCH)
) (
   input  logic [NCH-1:0] mask,
   output logic [NCH-1:0] low_oh,
   output logic [CW-1:0]  low_idx
);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_oh
         if (i == 0) begin : g_first
            assign low_oh[i] = mask[i];
         end else begin : g_rest
            assign low_oh[i] = mask[i] & ~(|mask[i-1:0]);
         end
      end
   endgenerate

   always_comb begin
      low_idx = '0;
      for (int i = 0; i < NCH; i++) begin
         if (low_oh[i]) low_idx = low_idx | CW'(i);
      end
   end

endmodule

// File: rtl/adc_seq_dcnt.sv
module adc_seq_dcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
   import adc_seq_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int DW        = 12,
   parameter int WR_CYC    = 2,
   parameter int START_CYC = 2,
   parameter int RD_CYC    = 2,
   parameter int QUIET_CYC = 6,
   localparam int CW = $clog2(NCH),
   localparam int PW = $clog2(max3(WR_CYC, START_CYC, RD_CYC) + 1) + 1,
   localparam int QW = $clog2(QUIET_CYC + 1) + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic [NCH-1:0] req_mask,
   output logic           req_ready,
   output logic           cv_cs_n,
   output logic           cv_wr_n,
   output logic           cv_rd_n,
   output logic           cv_start,
   input  logic           cv_eoc_n,
   output logic           cv_db_oe,
   output logic [NCH-1:0] cv_db_o,
   input  logic [DW-1:0]  cv_db_i,
   output logic           res_valid,
   output logic [DW-1:0]  res_data,
   output logic [CW-1:0]  res_chan,
   output logic           res_last
);

   initial begin
      AST_PARAM_NCH: assert (NCH >= 2) else $error("NCH must be at least 2");
      AST_PARAM_WR:  assert (WR_CYC >= 1) else $error("WR_CYC must be at least 1");
      AST_PARAM_ST:  assert (START_CYC >= 1) else $error("START_CYC must be at least 1");
      AST_PARAM_RD:  assert (RD_CYC >= 1) else $error("RD_CYC must be at least 1");
      AST_PARAM_QT:  assert (QUIET_CYC >= 0) else $error("QUIET_CYC must not be negative");
   end

   seq_state_e     state, nxt;
   logic [NCH-1:0] lat_mask, rem_mask, low_oh, rem_after;
   logic [CW-1:0]  low_idx;
   logic           ph_load, ph_zero, quiet_done, accept, rd_done, seq_end;
   logic [PW-1:0]  ph_val;

   // phase timer shared by write, start and read phases
   adc_seq_dcnt #(.W(PW)) u_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ph_load),
      .val  (ph_val),
      .zero (ph_zero)
   );

   adc_seq_pick #(.NCH(NCH)) u_pick (
      .mask   (rem_mask),
      .low_oh (low_oh),
      .low_idx(low_idx)
   );

   assign rem_after = rem_mask & ~low_oh;
   assign rd_done   = (state == ST_READ) && ph_zero;
   assign seq_end   = rd_done && (rem_after == '0);

   // quiet window: counter only when a nonzero window is configured
   generate
      if (QUIET_CYC > 0) begin : g_quiet
         adc_seq_dcnt #(.W(QW)) u_quiet (
            .clk  (clk),
            .rst_n(rst_n),
            .load (seq_end),
            .val  (QW'(QUIET_CYC)),
            .zero (quiet_done)
         );
      end else begin : g_noquiet
         assign quiet_done = 1'b1;
      end
   endgenerate

   assign req_ready = (state == ST_IDLE) && quiet_done;
   assign accept    = req_valid && req_ready && (req_mask != '0);

   always_comb begin
      nxt     = state;
      ph_load = 1'b0;
      ph_val  = '0;
      unique case (state)
         ST_IDLE: begin
            if (accept) begin
               nxt     = ST_WRITE;
               ph_load = 1'b1;
               ph_val  = PW'(WR_CYC - 1);
            end
         end
         ST_WRITE: if (ph_zero) nxt = ST_WGAP;
         ST_WGAP: begin
            nxt     = ST_START;
            ph_load = 1'b1;
            ph_val  = PW'(START_CYC - 1);
         end
         ST_START: if (ph_zero) nxt = ST_WAIT;
         ST_WAIT: begin
            if (!cv_eoc_n) begin
               nxt     = ST_READ;
               ph_load = 1'b1;
               ph_val  = PW'(RD_CYC - 1);
            end
         end
         ST_READ: if (ph_zero) nxt = ST_EOCHI;
         ST_EOCHI: begin
            if (cv_eoc_n) nxt = (rem_mask == '0) ? ST_IDLE : ST_WAIT;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         lat_mask <= '0;
         rem_mask <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            lat_mask <= req_mask;
            rem_mask <= req_mask;
         end else if (rd_done) begin
            rem_mask <= rem_after;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_chan  <= '0;
         res_last  <= 1'b0;
      end else begin
         res_valid <= rd_done;
         if (rd_done) begin
            res_data <= cv_db_i;
            res_chan <= low_idx;
            res_last <= (rem_after == '0);
         end
      end
   end

   assign cv_cs_n  = !((state == ST_WRITE) || (state == ST_READ));
   assign cv_wr_n  = (state != ST_WRITE);
   assign cv_rd_n  = (state != ST_READ);
   assign cv_start = (state == ST_START);
   assign cv_db_oe = (state == ST_WRITE) || (state == ST_WGAP);
   assign cv_db_o  = lat_mask;

   // cycles since read last went high, saturating; assertion support only
   logic [QW-1:0] gap_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        gap_cnt <= QW'(QUIET_CYC);
      else if (!cv_rd_n)                 gap_cnt <= '0;
      else if (gap_cnt < QW'(QUIET_CYC)) gap_cnt <= gap_cnt + 1'b1;
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!cv_wr_n, !cv_rd_n, cv_start})); // R3
   AST_WR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !cv_wr_n |-> (!cv_cs_n && cv_rd_n && cv_db_oe)); // R3
   AST_MASK_AT_WR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cv_wr_n) |-> (cv_db_oe && cv_db_o == lat_mask)); // R3
   AST_START_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cv_start) |-> $past(cv_db_oe)); // R4
   AST_READ_IN_EOC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cv_rd_n) |-> $past(!cv_eoc_n)); // R5
   AST_RESULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(!cv_rd_n) && cv_rd_n)); // R6
   AST_TAG_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> lat_mask[res_chan]); // R7
   AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cv_start) |-> (gap_cnt >= QW'(QUIET_CYC))); // R9
   AST_BUSY_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_last) |-> !req_ready); // R9

endmodule

// File: tb/adc_seq_host_bench.sv
module adc_seq_host_bench;

   localparam int WR_CYC = 2, START_CYC = 2, RD_CYC = 3, QUIET_CYC = 5;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_mask = '0;
   logic        req_ready, cv_cs_n, cv_wr_n, cv_rd_n, cv_start, cv_db_oe;
   logic        cv_eoc_n = 1'b1;
   logic [3:0]  cv_db_o;
   logic [11:0] cv_db_i = '0;
   logic        res_valid, res_last;
   logic [11:0] res_data;
   logic [1:0]  res_chan;

   always #4 clk = ~clk;

   adc_seq_host #(.NCH(4), .DW(12), .WR_CYC(WR_CYC), .START_CYC(START_CYC),
                  .RD_CYC(RD_CYC), .QUIET_CYC(QUIET_CYC)) u_adc_seq_host (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
      .req_ready(req_ready), .cv_cs_n(cv_cs_n), .cv_wr_n(cv_wr_n), .cv_rd_n(cv_rd_n),
      .cv_start(cv_start), .cv_eoc_n(cv_eoc_n), .cv_db_oe(cv_db_oe), .cv_db_o(cv_db_o),
      .cv_db_i(cv_db_i), .res_valid(res_valid), .res_data(res_data),
      .res_chan(res_chan), .res_last(res_last));

   int checks = 0, failures = 0;
   bit done = 0;
   int seq_no = 0;
   logic [3:0] exp_mask = '0;
   logic [3:0] conv_mask = '0;
   int conv_cyc = 3, eol_cyc = 5;
   int idx = 0;
   bit got_last = 0;
   int rd_falls = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   function automatic logic [11:0] sample_val(input int s, input int c);
      return 12'((s * 37 + c * 911 + 5) % 4096);
   endfunction

   function automatic int nth_chan(input logic [3:0] m, input int n);
      int k = 0;
      for (int c = 0; c < 4; c++) begin
         if (m[c]) begin
            if (k == n) return c;
            k++;
         end
      end
      return -1;
   endfunction

   function automatic int popc(input logic [3:0] m);
      return int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]);
   endfunction

   // converter model: mask latch on write rising edge, sequencer, eoc pulses
   logic wr_prev = 1'b1, st_prev = 1'b0;
   int   wr_low = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!cv_wr_n) begin
            wr_low++;
            chk(!cv_cs_n && cv_rd_n && cv_db_oe, "R3", "write frame cs/rd/oe", 0, 1);
         end
         if (!wr_prev && cv_wr_n) begin
            chk(wr_low == WR_CYC, "R3", "write low width", wr_low, WR_CYC);
            chk(cv_db_oe && cv_db_o == exp_mask, "R3", "mask on bus at write rise",
                int'(cv_db_o), int'(exp_mask));
            conv_mask = cv_db_o;
            wr_low = 0;
         end
         wr_prev = cv_wr_n;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cv_start && !st_prev) begin
            for (int c = 0; c < 4; c++) begin
               if (conv_mask[c]) begin
                  repeat (conv_cyc) @(negedge clk);
                  cv_eoc_n = 1'b0;
                  cv_db_i  = sample_val(seq_no, c);
                  rd_falls = 0;
                  repeat (eol_cyc) @(negedge clk);
                  cv_eoc_n = 1'b1;
                  chk(rd_falls == 1, "R5", "reads per eoc pulse", rd_falls, 1);
               end
            end
         end
         st_prev = cv_start;
      end
   end

   // strobe observers: read width, start width, quiet gap
   logic rd_prev = 1'b1, sp = 1'b0;
   int rd_low = 0, st_high = 0, rd_hi_run = 1000;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_prev && !cv_rd_n) begin
            rd_falls++;
            chk(!cv_eoc_n && !cv_cs_n, "R5", "read starts during eoc low", int'(cv_eoc_n), 0);
         end
         if (!cv_rd_n) rd_low++;
         if (!rd_prev && cv_rd_n) begin
            chk(rd_low == RD_CYC, "R5", "read low width", rd_low, RD_CYC);
            rd_low = 0;
         end
         if (cv_rd_n) rd_hi_run++; else rd_hi_run = 0;
         if (cv_start && !sp)
            chk(rd_hi_run >= QUIET_CYC, "R9", "quiet before start", rd_hi_run, QUIET_CYC);
         if (cv_start) st_high++;
         if (!cv_start && sp) begin
            chk(st_high == START_CYC, "R4", "start width", st_high, START_CYC);
            st_high = 0;
         end
         if (cv_start) chk(cv_wr_n && !cv_db_oe, "R4", "start after write", int'(cv_wr_n), 1);
         rd_prev = cv_rd_n;
         sp = cv_start;
      end
   end

   // result monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         int ec;
         ec = nth_chan(exp_mask, idx);
         chk(int'(res_chan) == ec, "R7", "channel tag", int'(res_chan), ec);
         chk(res_data == sample_val(seq_no, ec), "R6", "result data",
             int'(res_data), int'(sample_val(seq_no, ec)));
         chk(res_last == (idx == popc(exp_mask) - 1), "R8", "last flag",
             int'(res_last), int'(idx == popc(exp_mask) - 1));
         chk(cv_rd_n, "R6", "valid follows read end", int'(cv_rd_n), 1);
         idx++;
         if (res_last) begin
            got_last = 1;
            chk(!req_ready, "R9", "not ready at last result", int'(req_ready), 0);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(cv_cs_n && cv_wr_n && cv_rd_n && !cv_start && !cv_db_oe && !res_valid,
          "R1", "strobes during reset", 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cv_cs_n && cv_wr_n && cv_rd_n && !cv_start && !res_valid && req_ready,
          "R1", "state after reset", int'(req_ready), 1);

      // R2: zero mask request is ignored
      req_valid = 1'b1; req_mask = 4'b0000;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk(cv_cs_n && req_ready && !cv_start, "R2", "zero mask ignored", int'(cv_cs_n), 1);
      end

      for (int it = 0; it < 60; it++) begin
         logic [3:0] m;
         case (it)
            0: m = 4'b1111;
            1: m = 4'b0001;
            2: m = 4'b1000;
            3: m = 4'b1010;
            4: m = 4'b0110;
            default: begin
               m = 4'($urandom_range(1, 15));
            end
         endcase
         conv_cyc = (it < 3) ? START_CYC + 1 : START_CYC + 1 + int'($urandom_range(0, 5));
         eol_cyc  = (it == 0) ? RD_CYC + 2 : RD_CYC + 2 + int'($urandom_range(0, 8));
         while (!req_ready) @(negedge clk);
         seq_no++;
         exp_mask = m;
         idx = 0;
         got_last = 0;
         req_valid = 1'b1; req_mask = m;
         @(negedge clk);
         chk(!req_ready, "R2", "busy after accept", int'(req_ready), 0);
         // R10 and R2: changing mask and requesting while busy has no effect
         req_mask = ~m;
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
         req_mask = 4'($urandom_range(0, 15));
         wait (got_last);
         @(negedge clk);
         chk(idx == popc(m), "R10", "result count equals latched mask", idx, popc(m));
         chk(!req_ready, "R9", "quiet window holds ready low", int'(req_ready), 0);
      end
      repeat (20) @(negedge clk);
      chk(req_ready, "R9", "ready after quiet window", int'(req_ready), 1);
      finish_run();
   end

endmodule